// File: doc/BRIEF.md
# Complex Multiply-Accumulate Operating Unit

This block is the arithmetic heart of a frequency-domain block adaptive filter. For every frequency bin it forms the sum, over K filter partitions, of a complex input spectrum value multiplied by a complex coefficient. It has just two real multipliers, and their operand multiplexers are switched between two phases. The first phase of a product forms the two "same part" products, whose difference updates the real accumulator. The second phase forms the two "cross" products, whose sum updates the imaginary accumulator. One complex product therefore takes two clock cycles, and products follow each other with no gaps.

Coefficients live in an internal circular delay line with one word per product. In the first cycle of each product the line is read and written at the same position, and the line advances once the product ends. A pass either loads fresh coefficients from the coefficient ports, or reuses and rewrites the words it already holds. The spectrum operands are streamed in on the input ports. The block asks for each operand with a strobe, in bin-major order: all K partitions of bin 0, then bin 1, and so on. After the last partition of a bin, one rounded and saturated 16-bit complex result is presented. After the last bin, the block reports that the pass is complete.

The control is a four-state machine. ST_IDLE waits for start. ST_MUL_A is the first product cycle. ST_MUL_B is the second product cycle. ST_DONE holds the pass-complete flag. The transitions are as follows. ST_IDLE or ST_DONE moves to ST_MUL_A when start is seen. ST_MUL_A always moves to ST_MUL_B. ST_MUL_B moves back to ST_MUL_A while products remain, and to ST_DONE after the last partition of the last bin.

Top module: `cmac_unit`

## Requirements
- R1: After reset `op_take`, `res_valid` and `done` are all low, and the block sits in ST_IDLE.
- R2: Each complex product occupies exactly two cycles. `op_take` is high only in the first cycle of a product, which means it is high one cycle in two while running, and a pass contains exactly N_BINS*K_PARTS `op_take` cycles.
- R3: Operands are consumed in bin-major order, so product index j = bin*K_PARTS + partition. Input and coefficient ports are sampled at the end of each `op_take` cycle.
- R4: For each bin, the real result is the sum of (x_re*c_re - x_im*c_im) over its K_PARTS partitions. The imaginary result is the sum of (x_re*c_im + x_im*c_re) over the same partitions. The accumulators restart at partition 0, so nothing carries from one bin to the next.
- R5: The accumulated Q30 sums are converted to Q15 by adding 2^14 and then shifting right arithmetically by 15 (round half up).
- R6: After rounding, any value above 32767 is output as 32767, and any value below -32768 is output as -32768.
- R7: `res_valid` is a one-cycle pulse in the cycle after the second phase of a bin's last partition, and there are exactly N_BINS pulses per pass.
- R8: When `coef_load` is 1 in an `op_take` cycle, the coefficient ports are used and also stored at that delay-line position. When `coef_load` is 0, the word stored at that position on the previous pass is used and written back unchanged. The delay line is packed {re, im}.
- R9: `done` rises in the same cycle as the last `res_valid` of a pass. It stays high until a new start is accepted, and falls in the following cycle.
- R10: `start` has no effect while in ST_MUL_A or ST_MUL_B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (accepted in ST_IDLE or ST_DONE) |
| coef_load | input | 1 | Take coefficient from ports and store it, instead of reusing the stored word |
| x_re | input | DW | Input spectrum, real part (Q15) |
| x_im | input | DW | Input spectrum, imaginary part (Q15) |
| c_re | input | DW | Coefficient load value, real part (Q15) |
| c_im | input | DW | Coefficient load value, imaginary part (Q15) |
| op_take | output | 1 | Operands on the input ports are consumed at the end of this cycle |
| res_re | output | DW | Bin result, real part (Q15) |
| res_im | output | DW | Bin result, imaginary part (Q15) |
| res_valid | output | 1 | Result valid pulse |
| done | output | 1 | All bins of the pass have been produced |

## Verification
The datapath is exercised with five patterns.
- **Random operands with a load.** These separate the real from the imaginary combination and catch swapped cross products. They also catch partition order errors and sums leaking across bins.
- **A pass without a load.** The coefficient ports are driven with unrelated values, so a correct result can only come from the recirculated delay-line words.
- **Full-scale operands.** These drive both output clamps.
- **Small fractional values.** These land near half an LSB and expose the rounding rule.
- **A start pulse in the middle of a pass.** Any restart or extra product would show up in the strobe and result counts.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MUL_A = 2'd1,
        ST_MUL_B = 2'd2,
        ST_DONE  = 2'd3
    } cmac_state_e;

endpackage

// File: rtl/cmac_delay_line.sv
// Circular sequential-access coefficient store: read and write at the head
// in one cycle, head advances once per complex product.
module cmac_delay_line #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              advance,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     head_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
        end else if (advance) begin
            head_q <= (head_q == PW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[head_q] <= wr_word;
        end
    end

    assign rd_word = mem[head_q];

endmodule

// File: rtl/cmac_datapath.sv
// Two shared multipliers, phase-multiplexed operands, real/imag accumulators,
// Q15 round-and-saturate output stage.
module cmac_datapath #(
    parameter int DW    = 16,
    parameter int ACC_W = 36
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 phase_a,
    input  logic                 phase_b,
    input  logic                 clear,
    input  logic                 emit,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    output logic signed [DW-1:0] res_re,
    output logic signed [DW-1:0] res_im
);
    localparam int PW = 2 * DW;
    localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(1) << (DW - 2);
    localparam logic signed [ACC_W-1:0] Q_MAX = (ACC_W'(1) << (DW - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] Q_MIN = -(ACC_W'(1) << (DW - 1));

    logic signed [DW-1:0]    ar_q, ai_q, br_q, bi_q;
    logic signed [DW-1:0]    m0_l, m0_r, m1_l, m1_r;
    logic signed [PW-1:0]    p0, p1;
    logic signed [ACC_W-1:0] p0_x, p1_x;
    logic signed [ACC_W-1:0] acc_re, acc_im, acc_re_nxt, acc_im_nxt;

    function automatic logic signed [DW-1:0] to_q15(input logic signed [ACC_W-1:0] v);
        logic signed [ACC_W-1:0] r;
        r = (v + HALF) >>> (DW - 1);
        if (r > Q_MAX)      return Q_MAX[DW-1:0];
        else if (r < Q_MIN) return Q_MIN[DW-1:0];
        else                return r[DW-1:0];
    endfunction

    always_comb begin
        m0_l = phase_b ? ar_q : a_re;
        m0_r = phase_b ? bi_q : b_re;
        m1_l = phase_b ? ai_q : a_im;
        m1_r = phase_b ? br_q : b_im;
        p0   = m0_l * m0_r;
        p1   = m1_l * m1_r;
        p0_x = {{(ACC_W - PW){p0[PW-1]}}, p0};
        p1_x = {{(ACC_W - PW){p1[PW-1]}}, p1};
        acc_re_nxt = (clear ? '0 : acc_re) + (p0_x - p1_x);
        acc_im_nxt = (clear ? '0 : acc_im) + (p0_x + p1_x);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_q   <= '0;
            ai_q   <= '0;
            br_q   <= '0;
            bi_q   <= '0;
            acc_re <= '0;
            acc_im <= '0;
            res_re <= '0;
            res_im <= '0;
        end else begin
            if (phase_a) begin
                ar_q   <= a_re;
                ai_q   <= a_im;
                br_q   <= b_re;
                bi_q   <= b_im;
                acc_re <= acc_re_nxt;
            end
            if (phase_b) begin
                acc_im <= acc_im_nxt;
            end
            if (emit) begin
                res_re <= to_q15(acc_re);
                res_im <= to_q15(acc_im_nxt);
            end
        end
    end

endmodule

// File: rtl/cmac_unit.sv
module cmac_unit
    import cmac_pkg::*;
#(
    parameter int DW      = 16,
    parameter int N_BINS  = 128,
    parameter int K_PARTS = 8,
    parameter int ACC_W   = 36
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 coef_load,
    input  logic signed [DW-1:0] x_re,
    input  logic signed [DW-1:0] x_im,
    input  logic signed [DW-1:0] c_re,
    input  logic signed [DW-1:0] c_im,
    output logic                 op_take,
    output logic signed [DW-1:0] res_re,
    output logic signed [DW-1:0] res_im,
    output logic                 res_valid,
    output logic                 done
);
    localparam int DEPTH = N_BINS * K_PARTS;
    localparam int KW    = (K_PARTS > 1) ? $clog2(K_PARTS) : 1;
    localparam int BW    = (N_BINS > 1) ? $clog2(N_BINS) : 1;

    cmac_state_e state_q, state_d;
    logic [KW-1:0] part_q;
    logic [BW-1:0] bin_q;
    logic          phase_a, phase_b, last_part, last_bin, accept;
    logic [2*DW-1:0]      dl_rd, dl_wr;
    logic signed [DW-1:0] cf_re, cf_im;

    assign phase_a   = (state_q == ST_MUL_A);
    assign phase_b   = (state_q == ST_MUL_B);
    assign last_part = (part_q == KW'(K_PARTS - 1));
    assign last_bin  = (bin_q == BW'(N_BINS - 1));
    assign accept    = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_MUL_A;
            ST_MUL_A: state_d = ST_MUL_B;
            ST_MUL_B: state_d = (last_part && last_bin) ? ST_DONE : ST_MUL_A;
            ST_DONE:  if (start) state_d = ST_MUL_A;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_q    <= '0;
            bin_q     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= phase_b && last_part;
            if (accept) begin
                part_q <= '0;
                bin_q  <= '0;
            end else if (phase_b) begin
                part_q <= last_part ? '0 : part_q + 1'b1;
                if (last_part) bin_q <= last_bin ? '0 : bin_q + 1'b1;
            end
        end
    end

    assign op_take = phase_a;
    assign done    = (state_q == ST_DONE);

    // coefficient source: port on load, else recirculated delay-line word
    assign cf_re = coef_load ? c_re : dl_rd[2*DW-1:DW];
    assign cf_im = coef_load ? c_im : dl_rd[DW-1:0];
    assign dl_wr = {cf_re, cf_im};

    cmac_delay_line #(
        .WORD_W (2 * DW),
        .DEPTH  (DEPTH)
    ) u_dline (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (phase_a),
        .advance (phase_b),
        .wr_word (dl_wr),
        .rd_word (dl_rd)
    );

    cmac_datapath #(
        .DW    (DW),
        .ACC_W (ACC_W)
    ) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_a (phase_a),
        .phase_b (phase_b),
        .clear   (part_q == '0),
        .emit    (phase_b && last_part),
        .a_re    (x_re),
        .a_im    (x_im),
        .b_re    (cf_re),
        .b_im    (cf_im),
        .res_re  (res_re),
        .res_im  (res_im)
    );

endmodule

// File: rtl/cmac_unit_chk.sv
module cmac_unit_chk
    import cmac_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        op_take,
    input logic        res_valid,
    input logic        done,
    input cmac_state_e state
);
    p_take_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_take |=> !op_take);

    p_phase_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUL_A) |=> (state == ST_MUL_B));

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_valid_after_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($past(state) == ST_MUL_B));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !op_take);

    p_done_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && op_take));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_MUL_B) && start) |=> (state == ST_MUL_A || state == ST_DONE));

endmodule

bind cmac_unit cmac_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_take   (op_take),
    .res_valid (res_valid),
    .done      (done),
    .state     (state_q)
);

// File: tb/cmac_unit_bench.sv
module cmac_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB  = 6;
    localparam int KP  = 3;
    localparam int TOT = NB * KP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic coef_load = 1'b0;
    logic signed [15:0] x_re = '0, x_im = '0, c_re = '0, c_im = '0;
    logic op_take, res_valid, done;
    logic signed [15:0] res_re, res_im;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmac_unit #(.DW(16), .N_BINS(NB), .K_PARTS(KP), .ACC_W(36)) u_cmac_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .coef_load(coef_load),
        .x_re(x_re), .x_im(x_im), .c_re(c_re), .c_im(c_im),
        .op_take(op_take), .res_re(res_re), .res_im(res_im),
        .res_valid(res_valid), .done(done)
    );

    int n_tests = 0, n_fail = 0;
    int cyc = 0, rcv_cnt = 0, take_cnt = 0;
    bit finished = 0;
    string cur_tag = "R4";
    logic [31:0] exp_q[$];
    logic [31:0] lfsr = 32'h1d2c3b4a;

    logic signed [15:0] xr_a[TOT], xi_a[TOT], cr_a[TOT], ci_a[TOT];
    logic signed [15:0] st_re[TOT], st_im[TOT];
    logic signed [15:0] pr_re[TOT], pr_im[TOT];

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic signed [15:0] rnd16();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr[23:8];
    endfunction

    function automatic longint q15(longint v);
        longint r;
        r = (v + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && op_take) take_cnt++;
    end

    // monitor: pop and compare each result as it appears
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R7", "unexpected result", rcv_cnt, -1);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(res_re == $signed(e[31:16]), cur_tag, "real part", res_re, $signed(e[31:16]));
                check(res_im == $signed(e[15:0]), cur_tag, "imag part", res_im, $signed(e[15:0]));
                // R9: done only with the final result of the pass
                check(done == (rcv_cnt == NB - 1), "R9", "done vs last result", done, rcv_cnt == NB - 1);
            end
            rcv_cnt++;
        end
    end

    // driver: build the pass, push expectations, stream operands
    task automatic run_pass(int pat, bit load, bit inject, string tag);
        int j, t_last;
        for (int i = 0; i < TOT; i++) begin
            int b;
            b = i / KP;
            case (pat)
                0: begin xr_a[i] = rnd16(); xi_a[i] = rnd16(); pr_re[i] = rnd16(); pr_im[i] = rnd16(); end
                1: begin xr_a[i] = rnd16(); xi_a[i] = rnd16(); pr_re[i] = 16'sh7abc ^ 16'(i); pr_im[i] = -16'sd1; end
                2: begin
                    xr_a[i] = (b % 2 == 0) ? -16'sd32768 : 16'sd32767;
                    xi_a[i] = xr_a[i];
                    pr_re[i] = -16'sd32768; pr_im[i] = 16'sd32767;
                end
                default: begin
                    xr_a[i] = 16'(b - 2); xi_a[i] = 16'(i % 2);
                    pr_re[i] = 16'sd16384; pr_im[i] = -16'sd8192;
                end
            endcase
            if (load) begin st_re[i] = pr_re[i]; st_im[i] = pr_im[i]; end
            cr_a[i] = st_re[i];
            ci_a[i] = st_im[i];
        end
        for (int b = 0; b < NB; b++) begin
            longint sr, si;
            longint er, ei;
            sr = 0; si = 0;
            for (int k = 0; k < KP; k++) begin
                int i;
                i = b * KP + k;
                sr += longint'(xr_a[i]) * cr_a[i] - longint'(xi_a[i]) * ci_a[i];
                si += longint'(xr_a[i]) * ci_a[i] + longint'(xi_a[i]) * cr_a[i];
            end
            er = q15(sr);
            ei = q15(si);
            exp_q.push_back({er[15:0], ei[15:0]});
        end
        cur_tag = tag;
        rcv_cnt = 0;
        take_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R9", "done cleared after start", done, 0);
        j = 0;
        t_last = 0;
        while (j < TOT) begin
            start = 1'b0;
            if (op_take) begin
                if (j > 0) check(cyc - t_last == 2, "R2", "product spacing", cyc - t_last, 2);
                t_last = cyc;
                x_re = xr_a[j]; x_im = xi_a[j];
                c_re = pr_re[j]; c_im = pr_im[j];
                coef_load = load;
                if (inject && j == TOT / 2) start = 1'b1;   // R10: mid-pass start
                j++;
            end
            @(negedge clk);
        end
        start = 1'b0;
        for (int w = 0; w < 20 && !done; w++) @(negedge clk);
        repeat (5) @(negedge clk);
        check(rcv_cnt == NB, "R7", "results per pass", rcv_cnt, NB);
        check(exp_q.size() == 0, "R7", "results outstanding", exp_q.size(), 0);
        check(take_cnt == TOT, inject ? "R10" : "R2", "operand strobes per pass", take_cnt, TOT);
        check(done == 1'b1, "R9", "done held", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(op_take == 1'b0, "R1", "op_take after reset", op_take, 0);
        check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        run_pass(0, 1, 0, "R3/R4");   // random data, bin-major order
        run_pass(1, 0, 0, "R8");      // recirculated coefficients
        run_pass(2, 1, 0, "R6");      // both clamps
        run_pass(3, 1, 1, "R5");      // rounding, start injected mid-pass
        run_pass(1, 0, 0, "R8");      // reuse coefficients of the rounding pass
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule